// File: doc/BRIEF.md
# Write-Through Data Cache with Store Buffer

This block sits between a processor load/store port and a slower word-wide memory port. Lookups go through a direct-mapped array of 32 lines of 32 bytes, 1 KB in all, where every line keeps a valid flag and an address tag. The processor works on whole 32-bit words. A load that hits returns its word one cycle after it is accepted. A load that misses stalls the processor while the whole line is fetched from memory, one word at a time.

Every store goes to memory. If the line is present, the store also updates the cached word. If the line is absent, the cache is left as it is, so no line is allocated for a store. Each store is placed in a four-entry FIFO store buffer. A drain engine works on its own and retires the buffered stores to memory one at a time, oldest first. The processor therefore stalls on a store only when the buffer is full.

A load miss first waits until the buffer is empty and only then starts its line fetch. The fetched line therefore always includes every store made before the load. A read miss never writes to memory. The memory port uses a request/acknowledge handshake and its latency can vary.

Top module: `wtc_cache`

## Requirements
- R1: After reset, with no request present, cpu_stall, cpu_rvalid and mem_req are all low.
- R2: The processor address is decoded as tag in bits 31:10, line index in bits 9:5 and word in bits 4:2; bits 1:0 are ignored on loads. A load that hits is accepted without stall, and cpu_rvalid is high in the next cycle with the addressed word on cpu_rdata. cpu_rvalid is low in every other cycle.
- R3: A load that misses holds cpu_stall high while the line is fetched. The fetch is eight word reads at consecutive word addresses, starting at word 0 of the line. The load then completes with the fetched word.
- R4: A store that hits updates the cached word, and a later load of that word hits and returns the stored value.
- R5: A store that misses leaves the cache unchanged. A line that was present still hits and keeps its old data in the other words, and a load of the stored address still misses.
- R6: Every accepted store causes exactly one memory write with the same address and data. These writes happen in the order the stores were accepted.
- R7: A load miss issues no memory write of its own. Its line reads begin only after every earlier store has been written to memory, so the load returns the most recent store to its address.
- R8: A store is accepted without stall while the store buffer holds fewer than four entries.
- R9: The store buffer holds four entries. With slow memory, four back-to-back stores are accepted and a fifth stalls until an entry retires.
- R10: While mem_req is high and mem_ack has not arrived, mem_req stays high and mem_addr, mem_we and mem_wdata stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_stall | output | 1 | Request not accepted in this cycle |
| cpu_rvalid | output | 1 | Load data valid |
| cpu_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Single-cycle completion of the current request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The properties assume the processor holds cpu_req, cpu_we, cpu_addr and cpu_wdata steady for as long as cpu_stall is high. They also assume memory raises mem_ack for exactly one cycle and only while a request is pending, with read data valid in that same cycle. The bench drives each access at the falling edge and keeps it in place until it sees stall low. Its memory model acknowledges after a randomised or deliberately long wait, drops the acknowledge on the next falling edge, and never acknowledges when nothing is requested.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    parameter int ADDR_W     = 32;
    parameter int DATA_W     = 32;
    parameter int LINES      = 32;
    parameter int LINE_BYTES = 32;
    parameter int WB_DEPTH   = 4;

    localparam int BYTE_W   = DATA_W / 8;
    localparam int BSEL_W   = $clog2(BYTE_W);
    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int IDX_W    = $clog2(LINES);
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
    localparam int WPL      = LINE_BYTES / BYTE_W;
    localparam int WSEL_W   = $clog2(WPL);
    localparam int LINE_A_W = ADDR_W - OFF_W;
    localparam int WB_CNT_W = $clog2(WB_DEPTH + 1);
    localparam int WB_PTR_W = $clog2(WB_DEPTH);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_FILL
    } ctl_state_t;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store
    import wtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tag_en,
    input  logic [IDX_W-1:0]  tag_idx,
    input  logic [TAG_W-1:0]  tag_val,
    input  logic              tag_valid
);
    localparam int WORDS = LINES * WPL;

    logic [DATA_W-1:0] data_q [WORDS];
    logic [DATA_W-1:0] data_d [WORDS];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [TAG_W-1:0]  tag_d  [LINES];
    logic [LINES-1:0]  valid_q, valid_d;

    always_comb begin
        data_d  = data_q;
        tag_d   = tag_q;
        valid_d = valid_q;
        if (wr_en) begin
            data_d[{wr_idx, wr_word}] = wr_data;
        end
        if (tag_en) begin
            tag_d[tag_idx]   = tag_val;
            valid_d[tag_idx] = tag_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    always_ff @(posedge clk) begin
        data_q <= data_d;
        tag_q  <= tag_d;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[{rd_idx, rd_word}];
endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf
    import wtc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  wb_entry_t           push_entry,
    input  logic                pop,
    output wb_entry_t           head,
    output logic [WB_CNT_W-1:0] count
);
    typedef struct packed {
        wb_entry_t [WB_DEPTH-1:0] slot;
        logic [WB_PTR_W-1:0]      wr_ptr;
        logic [WB_PTR_W-1:0]      rd_ptr;
        logic [WB_CNT_W-1:0]      cnt;
    } wb_state_t;

    wb_state_t st_q, st_d;

    function automatic logic [WB_PTR_W-1:0] ptr_next(input logic [WB_PTR_W-1:0] p);
        if (p == WB_PTR_W'(WB_DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.slot[st_q.wr_ptr] = push_entry;
            st_d.wr_ptr            = ptr_next(st_q.wr_ptr);
        end
        if (pop) begin
            st_d.rd_ptr = ptr_next(st_q.rd_ptr);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.slot[st_q.rd_ptr];
    assign count = st_q.cnt;
endmodule

// File: rtl/wtc_mem_port.sv
module wtc_mem_port
    import wtc_pkg::*;
(
    input  logic              filling,
    input  logic [ADDR_W-1:0] fill_addr,
    input  wb_entry_t         wb_head,
    input  logic              wb_empty,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wb_pop,
    output logic              fill_ack
);
    logic drain_active;

    always_comb begin
        drain_active = !filling && !wb_empty;
        mem_req      = filling || drain_active;
        mem_we       = drain_active;
        mem_addr     = filling ? fill_addr : wb_head.addr;
        mem_wdata    = wb_head.data;
        wb_pop       = drain_active && mem_ack;
        fill_ack     = filling && mem_ack;
    end
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
    import wtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_stall,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    typedef struct packed {
        ctl_state_t            state;
        logic [WSEL_W-1:0]     fill_word;
        logic [LINE_A_W-1:0]   miss_line;
        logic                  rvalid;
        logic [DATA_W-1:0]     rdata;
    } ctl_regs_t;

    ctl_regs_t cs_q, cs_d;

    logic [TAG_W-1:0]    a_tag;
    logic [IDX_W-1:0]    a_idx;
    logic [WSEL_W-1:0]   a_word;
    logic                rd_valid;
    logic [TAG_W-1:0]    rd_tag;
    logic [DATA_W-1:0]   rd_data;
    logic                hit;
    logic                wr_en;
    logic [IDX_W-1:0]    wr_idx;
    logic [WSEL_W-1:0]   wr_word;
    logic [DATA_W-1:0]   wr_data;
    logic                tag_en;
    logic [IDX_W-1:0]    tag_idx;
    logic [TAG_W-1:0]    tag_val;
    logic                tag_valid;
    logic                wb_push;
    logic                wb_pop;
    wb_entry_t           wb_head;
    wb_entry_t           wb_in;
    logic [WB_CNT_W-1:0] wb_count;
    logic                wb_full;
    logic                wb_empty;
    logic                filling;
    logic                fill_ack;
    logic [ADDR_W-1:0]   fill_addr;
    logic                stall;

    assign a_tag    = cpu_addr[ADDR_W-1:OFF_W+IDX_W];
    assign a_idx    = cpu_addr[OFF_W+IDX_W-1:OFF_W];
    assign a_word   = cpu_addr[OFF_W-1:BSEL_W];
    assign wb_full  = (wb_count == WB_CNT_W'(WB_DEPTH));
    assign wb_empty = (wb_count == '0);
    assign hit      = rd_valid && (rd_tag == a_tag);
    assign wb_in    = '{addr: cpu_addr, data: cpu_wdata};
    assign filling  = (cs_q.state == ST_FILL);
    assign fill_addr = {cs_q.miss_line, cs_q.fill_word, {BSEL_W{1'b0}}};

    always_comb begin
        cs_d      = cs_q;
        cs_d.rvalid = 1'b0;
        stall     = 1'b0;
        wb_push   = 1'b0;
        wr_en     = 1'b0;
        wr_idx    = a_idx;
        wr_word   = a_word;
        wr_data   = cpu_wdata;
        tag_en    = 1'b0;
        tag_idx   = cs_q.miss_line[IDX_W-1:0];
        tag_val   = cs_q.miss_line[LINE_A_W-1:IDX_W];
        tag_valid = 1'b0;
        case (cs_q.state)
            ST_IDLE: begin
                if (cpu_req && !cpu_we) begin
                    if (hit) begin
                        cs_d.rvalid = 1'b1;
                        cs_d.rdata  = rd_data;
                    end else begin
                        stall          = 1'b1;
                        cs_d.state     = ST_DRAIN;
                        cs_d.miss_line = cpu_addr[ADDR_W-1:OFF_W];
                    end
                end else if (cpu_req && cpu_we) begin
                    if (wb_full) begin
                        stall = 1'b1;
                    end else begin
                        wb_push = 1'b1;
                        wr_en   = hit;
                    end
                end
            end
            ST_DRAIN: begin
                stall = 1'b1;
                if (wb_empty) begin
                    cs_d.state     = ST_FILL;
                    cs_d.fill_word = '0;
                    tag_en         = 1'b1;
                    tag_valid      = 1'b0;
                end
            end
            ST_FILL: begin
                stall = 1'b1;
                if (fill_ack) begin
                    wr_en   = 1'b1;
                    wr_idx  = cs_q.miss_line[IDX_W-1:0];
                    wr_word = cs_q.fill_word;
                    wr_data = mem_rdata;
                    if (cs_q.fill_word == WSEL_W'(WPL - 1)) begin
                        tag_en     = 1'b1;
                        tag_valid  = 1'b1;
                        cs_d.state = ST_IDLE;
                    end else begin
                        cs_d.fill_word = cs_q.fill_word + 1'b1;
                    end
                end
            end
            default: begin
                cs_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign cpu_stall  = stall;
    assign cpu_rvalid = cs_q.rvalid;
    assign cpu_rdata  = cs_q.rdata;

    wtc_line_store u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (a_idx),
        .rd_word   (a_word),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_word   (wr_word),
        .wr_data   (wr_data),
        .tag_en    (tag_en),
        .tag_idx   (tag_idx),
        .tag_val   (tag_val),
        .tag_valid (tag_valid)
    );

    wtc_wbuf u_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wb_push),
        .push_entry (wb_in),
        .pop        (wb_pop),
        .head       (wb_head),
        .count      (wb_count)
    );

    wtc_mem_port u_port (
        .filling   (filling),
        .fill_addr (fill_addr),
        .wb_head   (wb_head),
        .wb_empty  (wb_empty),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .wb_pop    (wb_pop),
        .fill_ack  (fill_ack)
    );
endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk
    import wtc_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cpu_req,
    input logic                cpu_we,
    input logic                cpu_stall,
    input logic                cpu_rvalid,
    input logic                mem_req,
    input logic                mem_we,
    input logic                mem_ack,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic [WB_CNT_W-1:0] wb_count
);
    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7
    fill_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (wb_count == '0));

    // R9
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && (wb_count == WB_CNT_W'(WB_DEPTH))) |-> cpu_stall);

    // R6
    store_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !cpu_stall) |=> (wb_count != '0));

    // R2
    load_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !cpu_stall) |=> cpu_rvalid);

    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_req && !cpu_we && !cpu_stall) |=> !cpu_rvalid);
endmodule

bind wtc_cache wtc_cache_chk u_wtc_cache_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_stall  (cpu_stall),
    .cpu_rvalid (cpu_rvalid),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .wb_count   (wb_count)
);

// File: tb/wtc_cache_bench.sv
`timescale 1ns/1ps
module wtc_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_stall;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    wtc_cache u_wtc_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_stall  (cpu_stall),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] ref_mem [4096];
    logic [31:0] dmem [4096];
    logic [31:0] lq [$];
    logic [63:0] wq [$];
    int mem_writes = 0;
    int mem_reads = 0;
    int stores = 0;
    bit slow = 1'b0;
    int lat = 0;
    int wcnt = 0;
    bit busy = 1'b0;
    logic [31:0] h_addr;
    logic [31:0] h_data;
    logic        h_we;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // driver: one processor access, pushes expected items into scoreboard queues
    task automatic op(input bit we, input logic [31:0] a, input logic [31:0] d, output int sc);
        sc = 0;
        @(negedge clk);
        cpu_req = 1'b1;
        cpu_we = we;
        cpu_addr = a;
        cpu_wdata = d;
        #1;
        while (cpu_stall) begin
            sc++;
            @(negedge clk);
            #1;
        end
        if (we) begin
            ref_mem[a[13:2]] = d;
            wq.push_back({a, d});
            stores++;
        end else begin
            lq.push_back(ref_mem[a[13:2]]);
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic wait_drained();
        for (int k = 0; k < 2000 && wq.size() != 0; k++) begin
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    // monitor: load responses against the reference model
    always @(negedge clk) begin
        if (rst_n) begin
            if (cpu_rvalid) begin
                if (lq.size() == 0) begin
                    chk(1'b0, "R2 rvalid without accepted load", {31'd0, cpu_rvalid}, 32'd0);
                end else begin
                    logic [31:0] e;
                    e = lq.pop_front();
                    chk(cpu_rdata == e, "R2/R3/R4/R7 load data", cpu_rdata, e);
                end
            end else if (lq.size() != 0) begin
                chk(1'b0, "R2 rvalid missing the cycle after accept", 32'd0, 32'd1);
                void'(lq.pop_front());
            end
        end
    end

    // memory model with variable latency
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (rst_n && mem_req) begin
            if (!busy) begin
                busy = 1'b1;
                h_addr = mem_addr;
                h_we = mem_we;
                h_data = mem_wdata;
                wcnt = 0;
            end else if (mem_addr != h_addr || mem_we != h_we || (h_we && mem_wdata != h_data)) begin
                chk(1'b0, "R10 request changed before ack", mem_addr, h_addr);
            end
            if (wcnt >= lat) begin
                mem_ack = 1'b1;
                busy = 1'b0;
                if (mem_we) begin
                    mem_writes++;
                    if (wq.size() == 0) begin
                        chk(1'b0, "R6 memory write with no pending store", mem_addr, 32'd0);
                    end else begin
                        logic [63:0] e;
                        e = wq.pop_front();
                        chk(mem_addr == e[63:32] && mem_wdata == e[31:0], "R6 write address/data/order",
                            mem_addr ^ mem_wdata, e[63:32] ^ e[31:0]);
                    end
                    dmem[mem_addr[13:2]] = mem_wdata;
                end else begin
                    chk(mem_addr[1:0] == 2'b00 && mem_addr[4:2] == 3'(mem_reads % 8),
                        "R3 fill word sequence", mem_addr, {27'd0, 3'(mem_reads % 8), 2'b00});
                    chk(wq.size() == 0, "R7 fill read before earlier stores retired", wq.size(), 32'd0);
                    mem_reads++;
                    mem_rdata = dmem[mem_addr[13:2]];
                end
                lat = slow ? 10 : int'($urandom % 4);
            end else begin
                wcnt++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        int sc;
        int r0;
        for (int i = 0; i < 4096; i++) begin
            ref_mem[i] = 32'h5A00_0000 ^ (i * 32'h0000_9E37);
            dmem[i] = ref_mem[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(cpu_stall == 1'b0, "R1 stall after reset", {31'd0, cpu_stall}, 32'd0);
        chk(cpu_rvalid == 1'b0, "R1 rvalid after reset", {31'd0, cpu_rvalid}, 32'd0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", {31'd0, mem_req}, 32'd0);

        // R3 cold miss fetches a whole line
        r0 = mem_reads;
        op(1'b0, 32'h0000_0108, '0, sc);
        chk(sc >= 8, "R3 load miss stalls during fill", sc, 32'd8);
        idle();
        chk(mem_reads - r0 == 8, "R3 eight word reads per fill", mem_reads - r0, 32'd8);

        // R2 hits in the filled line, low address bits ignored
        op(1'b0, 32'h0000_0108, '0, sc);
        chk(sc == 0, "R2 hit without stall", sc, 0);
        op(1'b0, 32'h0000_011F, '0, sc);
        chk(sc == 0, "R2 hit on last word", sc, 0);
        op(1'b0, 32'h0000_0100, '0, sc);
        chk(sc == 0, "R2 hit on first word", sc, 0);

        // R4 store hit, then load
        op(1'b1, 32'h0000_0104, 32'hDEAD_BEEF, sc);
        chk(sc == 0, "R8 store with room", sc, 0);
        op(1'b0, 32'h0000_0104, '0, sc);
        chk(sc == 0, "R4 load after store hit", sc, 0);

        // R5 store miss to a different tag at the same index
        op(1'b1, 32'h0000_2104, 32'h1234_5678, sc);
        chk(sc == 0, "R8 store miss with room", sc, 0);
        op(1'b0, 32'h0000_0104, '0, sc);
        chk(sc == 0, "R5 resident line still hits", sc, 0);
        op(1'b0, 32'h0000_2104, '0, sc);
        chk(sc > 0, "R5 store miss did not allocate", sc, 1);
        idle();

        // R9 buffer capacity with slow memory
        wait_drained();
        slow = 1'b1;
        lat = 10;
        for (int k = 0; k < 4; k++) begin
            op(1'b1, 32'h0000_0300 + 32'(k * 4), 32'hA000_0000 + 32'(k), sc);
            chk(sc == 0, "R9 store accepted while not full", sc, 0);
        end
        op(1'b1, 32'h0000_0310, 32'hA000_0004, sc);
        chk(sc > 0, "R9 fifth store stalls", sc, 1);
        op(1'b0, 32'h0000_0308, '0, sc);
        chk(sc > 0, "R7 load miss after buffered stores", sc, 1);
        idle();
        wait_drained();
        slow = 1'b0;
        lat = 0;

        // mixed traffic over conflicting lines
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            bit we;
            we = bit'($urandom % 2);
            a = 32'(($urandom % 3) * 1024 + ($urandom % 4) * 32 + ($urandom % 8) * 4);
            op(we, a, $urandom, sc);
        end
        idle();
        wait_drained();

        chk(mem_writes == stores, "R6 one memory write per store", mem_writes, stores);
        chk(wq.size() == 0, "R6 all stores retired", wq.size(), 32'd0);
        chk(lq.size() == 0, "R2 all loads answered", lq.size(), 32'd0);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 4096; i++) begin
                if (dmem[i] != ref_mem[i]) bad++;
            end
            chk(bad == 0, "R6 memory image matches reference", bad, 32'd0);
        end
        finish_up();
    end
endmodule